// File: doc/BRIEF.md
# Floating-Point Status Register Access Trap Decision

This block decides what happens when software running at privilege level 0, 1, 2 or 3 tries to read or write the floating-point status register. It takes the current level and a set of configuration bits from the three higher levels: whether each level is present or enabled, whether it runs 64-bit state, the host-mode and trap-general routing bits, the 2-bit access-enable fields of levels 1 and 2, and the trap-FP bits of levels 2 and 3. It also takes the debug-halt and secure-debug-disable signals. From these it returns exactly one verdict. The access is allowed, it is undefined, or it traps to a named level with a syndrome class.

The verdict is taken from an ordered chain of checks whose contents depend on the current level. The first check that matches decides the outcome. Reads and writes are judged by the same rules, so the block has no read/write input; only the effect of an allowed access differs, and that effect lies outside this block. The inputs are sampled on each rising clock edge and the verdict is registered, so it shows on the outputs one cycle later.

Top module: `fpac_decide`

## Requirements
- R1: While reset is asserted (rst_n low), allow_o, undef_o and trap_o are 0, and tgt_lvl_o and syn_o are 0.
- R2: At level 3 (cur_lvl_i = 3), the access traps to level 3 with syndrome 0x07 when l3_fp_trap_i is 1, and is allowed otherwise. The halted and debug inputs have no effect at level 3.
- R3: At levels 0 to 2, with parameter HALT_UNDEF_FIRST = 1, the access is undefined when all of the following hold: halted_i, sdbg_dis_i, l3_here_i, l3_w64_i and l3_fp_trap_i are 1. This check ranks above every other check.
- R4: At level 0, suppose l1_w64_i is 1, l1_fp_en_i is not 2'b11, and it is not the case that l2_on_i, host_i and tgen_i are all 1. The access then traps. It goes to level 2 with syndrome 0x00 when l2_on_i, l2_w64_i and tgen_i are all 1, and to level 1 with syndrome 0x07 otherwise.
- R5: At level 0, when l2_on_i, l2_w64_i, host_i and tgen_i are all 1 and l2_fp_en_i is not 2'b11, the access traps to level 2 with syndrome 0x07.
- R6: At level 1, when bit 0 of l1_fp_en_i is 0, the access traps to level 1 with syndrome 0x07.
- R7: At levels 0 to 2, with l2_on_i and l2_w64_i both 1, the access traps to level 2 with syndrome 0x07 in two cases: host_i is 1 and bit 0 of l2_fp_en_i is 0, or host_i is 0 and l2_fp_trap_i is 1.
- R8: The last check at levels 0 to 2 applies when l3_here_i, l3_w64_i and l3_fp_trap_i are all 1. The access is then undefined if halted_i and sdbg_dis_i are both 1, and traps to level 3 with syndrome 0x07 otherwise.
- R9: When no check matches, the access is allowed.
- R10: Out of reset, exactly one of allow_o, undef_o and trap_o is 1. tgt_lvl_o and syn_o are 0 whenever trap_o is 0.
- R11: The checks form an ordered chain, and the first one that matches decides the verdict. The chain order is R3, then R4 or R6, then R5, then R7, then R8.
- R12: The verdict for the inputs sampled at one rising edge appears on the outputs after that edge and stays until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_lvl_i | input | 2 | Current privilege level 0..3 |
| l1_w64_i | input | 1 | Level 1 runs 64-bit state |
| l2_on_i | input | 1 | Level 2 is present and enabled |
| l2_w64_i | input | 1 | Level 2 runs 64-bit state |
| l3_here_i | input | 1 | Level 3 is present |
| l3_w64_i | input | 1 | Level 3 runs 64-bit state |
| host_i | input | 1 | Level-2 host-mode bit |
| tgen_i | input | 1 | Level-2 trap-general bit |
| l1_fp_en_i | input | 2 | Level-1 FP access-enable field |
| l2_fp_en_i | input | 2 | Level-2 FP access-enable field |
| l2_fp_trap_i | input | 1 | Level-2 trap-FP bit |
| l3_fp_trap_i | input | 1 | Level-3 trap-FP bit |
| halted_i | input | 1 | Core is in debug halt |
| sdbg_dis_i | input | 1 | Secure debug disabled |
| allow_o | output | 1 | Access proceeds |
| undef_o | output | 1 | Access is undefined |
| trap_o | output | 1 | Access traps |
| tgt_lvl_o | output | 2 | Trap target level (0 unless trap) |
| syn_o | output | 6 | Syndrome class (0 unless trap) |

## Verification
The bench sweeps all 131072 combinations of the 17 input bits. It compares every verdict with a model built straight from the rule chain, and it tags each comparison with the rule that should decide it. Level 3 vectors show that the debug inputs are ignored there. Level 0 vectors with trap-general set and cleared separate the syndrome 0x00 reroute to level 2 from the ordinary level-1 trap. Vectors in which several rules match at once show that chain order wins: the halt rule beats a level-1 trap, and a level-1 trap beats a level-2 trap. Halted vectors with and without secure debug disabled separate the undefined outcome from the level-3 trap.

// File: rtl/fpac_pkg.sv
package fpac_pkg;
    localparam int LVL_W = 2;
    localparam int SYN_W = 6;
    localparam logic [SYN_W-1:0] SYN_FP_TRAP = 6'h07;
    localparam logic [SYN_W-1:0] SYN_UNCAT   = 6'h00;

    typedef struct packed {
        logic             hit;
        logic             undef;
        logic [LVL_W-1:0] tgt;
        logic [SYN_W-1:0] syn;
    } rule_hit_t;

    typedef struct packed {
        logic             allow;
        logic             undef;
        logic             trap;
        logic [LVL_W-1:0] tgt;
        logic [SYN_W-1:0] syn;
    } verdict_t;

    localparam rule_hit_t NO_HIT = '{hit: 1'b0, undef: 1'b0, tgt: '0, syn: '0};

    function automatic rule_hit_t trap_to(input logic [LVL_W-1:0] lvl,
                                          input logic [SYN_W-1:0] code);
        rule_hit_t r;
        r.hit   = 1'b1;
        r.undef = 1'b0;
        r.tgt   = lvl;
        r.syn   = code;
        return r;
    endfunction

    function automatic rule_hit_t undef_hit();
        rule_hit_t r;
        r       = NO_HIT;
        r.hit   = 1'b1;
        r.undef = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/fpac_gate_low.sv
module fpac_gate_low
    import fpac_pkg::*;
(
    input  logic [LVL_W-1:0] cur_lvl_i,
    input  logic             l1_w64_i,
    input  logic             l2_on_i,
    input  logic             l2_w64_i,
    input  logic             host_i,
    input  logic             tgen_i,
    input  logic [1:0]       l1_fp_en_i,
    output rule_hit_t        hit_o
);
    logic host_route;
    assign host_route = l2_on_i & host_i & tgen_i;

    always_comb begin
        hit_o = NO_HIT;
        if (cur_lvl_i == 2'd0) begin
            if (l1_w64_i && !host_route && (l1_fp_en_i != 2'b11)) begin
                if (l2_on_i && l2_w64_i && tgen_i)
                    hit_o = trap_to(2'd2, SYN_UNCAT);
                else
                    hit_o = trap_to(2'd1, SYN_FP_TRAP);
            end
        end else if (cur_lvl_i == 2'd1) begin
            if (!l1_fp_en_i[0])
                hit_o = trap_to(2'd1, SYN_FP_TRAP);
        end
    end
endmodule

// File: rtl/fpac_gate_hyp.sv
module fpac_gate_hyp
    import fpac_pkg::*;
(
    input  logic [LVL_W-1:0] cur_lvl_i,
    input  logic             l2_on_i,
    input  logic             l2_w64_i,
    input  logic             host_i,
    input  logic             tgen_i,
    input  logic [1:0]       l2_fp_en_i,
    input  logic             l2_fp_trap_i,
    output rule_hit_t        hit_o
);
    logic l2_live;
    assign l2_live = l2_on_i & l2_w64_i;

    always_comb begin
        hit_o = NO_HIT;
        if (cur_lvl_i != 2'd3 && l2_live) begin
            if (cur_lvl_i == 2'd0 && host_i && tgen_i && (l2_fp_en_i != 2'b11))
                hit_o = trap_to(2'd2, SYN_FP_TRAP);
            else if (host_i && !l2_fp_en_i[0])
                hit_o = trap_to(2'd2, SYN_FP_TRAP);
            else if (!host_i && l2_fp_trap_i)
                hit_o = trap_to(2'd2, SYN_FP_TRAP);
        end
    end
endmodule

// File: rtl/fpac_gate_mon.sv
module fpac_gate_mon
    import fpac_pkg::*;
(
    input  logic [LVL_W-1:0] cur_lvl_i,
    input  logic             l3_here_i,
    input  logic             l3_w64_i,
    input  logic             l3_fp_trap_i,
    input  logic             dbg_lock_i,
    output rule_hit_t        hit_o
);
    always_comb begin
        hit_o = NO_HIT;
        if (cur_lvl_i == 2'd3) begin
            if (l3_fp_trap_i)
                hit_o = trap_to(2'd3, SYN_FP_TRAP);
        end else if (l3_here_i && l3_w64_i && l3_fp_trap_i) begin
            if (dbg_lock_i)
                hit_o = undef_hit();
            else
                hit_o = trap_to(2'd3, SYN_FP_TRAP);
        end
    end
endmodule

// File: rtl/fpac_decide.sv
module fpac_decide
    import fpac_pkg::*;
#(
    parameter bit HALT_UNDEF_FIRST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] cur_lvl_i,
    input  logic             l1_w64_i,
    input  logic             l2_on_i,
    input  logic             l2_w64_i,
    input  logic             l3_here_i,
    input  logic             l3_w64_i,
    input  logic             host_i,
    input  logic             tgen_i,
    input  logic [1:0]       l1_fp_en_i,
    input  logic [1:0]       l2_fp_en_i,
    input  logic             l2_fp_trap_i,
    input  logic             l3_fp_trap_i,
    input  logic             halted_i,
    input  logic             sdbg_dis_i,
    output logic             allow_o,
    output logic             undef_o,
    output logic             trap_o,
    output logic [LVL_W-1:0] tgt_lvl_o,
    output logic [SYN_W-1:0] syn_o
);
    rule_hit_t low_hit, hyp_hit, mon_hit, halt_hit;
    verdict_t  verdict_d, verdict_q;
    logic      dbg_lock;

    assign dbg_lock = halted_i & sdbg_dis_i;

    generate
        if (HALT_UNDEF_FIRST) begin : g_halt_first
            always_comb begin
                halt_hit = NO_HIT;
                if (cur_lvl_i != 2'd3 && dbg_lock && l3_here_i && l3_w64_i && l3_fp_trap_i)
                    halt_hit = undef_hit();
            end
        end else begin : g_halt_late
            assign halt_hit = NO_HIT;
        end
    endgenerate

    fpac_gate_low u_low (
        .cur_lvl_i  (cur_lvl_i),
        .l1_w64_i   (l1_w64_i),
        .l2_on_i    (l2_on_i),
        .l2_w64_i   (l2_w64_i),
        .host_i     (host_i),
        .tgen_i     (tgen_i),
        .l1_fp_en_i (l1_fp_en_i),
        .hit_o      (low_hit)
    );

    fpac_gate_hyp u_hyp (
        .cur_lvl_i    (cur_lvl_i),
        .l2_on_i      (l2_on_i),
        .l2_w64_i     (l2_w64_i),
        .host_i       (host_i),
        .tgen_i       (tgen_i),
        .l2_fp_en_i   (l2_fp_en_i),
        .l2_fp_trap_i (l2_fp_trap_i),
        .hit_o        (hyp_hit)
    );

    fpac_gate_mon u_mon (
        .cur_lvl_i    (cur_lvl_i),
        .l3_here_i    (l3_here_i),
        .l3_w64_i     (l3_w64_i),
        .l3_fp_trap_i (l3_fp_trap_i),
        .dbg_lock_i   (dbg_lock),
        .hit_o        (mon_hit)
    );

    always_comb begin
        rule_hit_t win;
        if (halt_hit.hit)      win = halt_hit;
        else if (low_hit.hit)  win = low_hit;
        else if (hyp_hit.hit)  win = hyp_hit;
        else                   win = mon_hit;

        verdict_d       = '0;
        verdict_d.allow = !win.hit;
        verdict_d.undef = win.hit & win.undef;
        verdict_d.trap  = win.hit & !win.undef;
        if (verdict_d.trap) begin
            verdict_d.tgt = win.tgt;
            verdict_d.syn = win.syn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) verdict_q <= '0;
        else        verdict_q <= verdict_d;
    end

    assign allow_o   = verdict_q.allow;
    assign undef_o   = verdict_q.undef;
    assign trap_o    = verdict_q.trap;
    assign tgt_lvl_o = verdict_q.tgt;
    assign syn_o     = verdict_q.syn;
endmodule

// File: rtl/fpac_decide_chk.sv
module fpac_decide_chk
    import fpac_pkg::*;
#(
    parameter bit HALT_UNDEF_FIRST = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] cur_lvl_i,
    input logic             l1_fp_en_i,
    input logic             l3_here_i,
    input logic             l3_w64_i,
    input logic             l3_fp_trap_i,
    input logic             halted_i,
    input logic             sdbg_dis_i,
    input logic             allow_o,
    input logic             undef_o,
    input logic             trap_o,
    input logic [LVL_W-1:0] tgt_lvl_o,
    input logic [SYN_W-1:0] syn_o
);
    logic lock3;
    assign lock3 = halted_i & sdbg_dis_i & l3_here_i & l3_w64_i & l3_fp_trap_i;

    a_r10_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones({allow_o, undef_o, trap_o}) == 1);

    a_r10_quiet_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> (tgt_lvl_o == 2'd0 && syn_o == 6'd0));

    a_r2_top_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl_i == 2'd3 && l3_fp_trap_i) |=> (trap_o && tgt_lvl_o == 2'd3 && syn_o == SYN_FP_TRAP));

    a_r2_top_allow: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl_i == 2'd3 && !l3_fp_trap_i) |=> allow_o);

    a_r6_l1_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl_i == 2'd1 && !l1_fp_en_i && !(HALT_UNDEF_FIRST && lock3))
        |=> (trap_o && tgt_lvl_o == 2'd1));

    a_r8_never_allow: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl_i != 2'd3 && l3_here_i && l3_w64_i && l3_fp_trap_i) |=> !allow_o);

    a_r3_halt_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (HALT_UNDEF_FIRST && cur_lvl_i != 2'd3 && lock3) |=> undef_o);
endmodule

bind fpac_decide fpac_decide_chk #(.HALT_UNDEF_FIRST(HALT_UNDEF_FIRST)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_lvl_i    (cur_lvl_i),
    .l1_fp_en_i   (l1_fp_en_i[0]),
    .l3_here_i    (l3_here_i),
    .l3_w64_i     (l3_w64_i),
    .l3_fp_trap_i (l3_fp_trap_i),
    .halted_i     (halted_i),
    .sdbg_dis_i   (sdbg_dis_i),
    .allow_o      (allow_o),
    .undef_o      (undef_o),
    .trap_o       (trap_o),
    .tgt_lvl_o    (tgt_lvl_o),
    .syn_o        (syn_o)
);

// File: tb/fpac_decide_tb.sv
module fpac_decide_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [16:0] vec = '0;
    logic       allow_o, undef_o, trap_o;
    logic [1:0] tgt_lvl_o;
    logic [5:0] syn_o;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         cycles = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    fpac_decide dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cur_lvl_i    (vec[1:0]),
        .l1_w64_i     (vec[2]),
        .l2_on_i      (vec[3]),
        .l2_w64_i     (vec[4]),
        .l3_here_i    (vec[5]),
        .l3_w64_i     (vec[6]),
        .host_i       (vec[7]),
        .tgen_i       (vec[8]),
        .l1_fp_en_i   (vec[10:9]),
        .l2_fp_en_i   (vec[12:11]),
        .l2_fp_trap_i (vec[13]),
        .l3_fp_trap_i (vec[14]),
        .halted_i     (vec[15]),
        .sdbg_dis_i   (vec[16]),
        .allow_o      (allow_o),
        .undef_o      (undef_o),
        .trap_o       (trap_o),
        .tgt_lvl_o    (tgt_lvl_o),
        .syn_o        (syn_o)
    );

    // expected packed as {allow, undef, trap, tgt[1:0], syn[5:0]}
    function automatic logic [10:0] model(input logic [16:0] v, output string tag);
        logic [1:0] lv   = v[1:0];
        logic l1w = v[2], l2on = v[3], l2w = v[4], l3h = v[5], l3w = v[6];
        logic hm = v[7], tg = v[8];
        logic [1:0] e1 = v[10:9], e2 = v[12:11];
        logic t2 = v[13], t3 = v[14], hl = v[15], sd = v[16];
        logic l2x = l2on & l2w;
        logic l3x = l3h & l3w & t3;
        if (lv == 2'd3) begin
            tag = "R2";
            return t3 ? {3'b001, 2'd3, 6'h07} : {3'b100, 2'd0, 6'h00};
        end
        if (hl && sd && l3x) begin tag = "R3"; return {3'b010, 8'h00}; end
        if (lv == 2'd0 && l1w && !(l2on && hm && tg) && e1 != 2'b11) begin
            tag = "R4";
            return (l2x && tg) ? {3'b001, 2'd2, 6'h00} : {3'b001, 2'd1, 6'h07};
        end
        if (lv == 2'd1 && !e1[0]) begin tag = "R6"; return {3'b001, 2'd1, 6'h07}; end
        if (lv == 2'd0 && l2x && hm && tg && e2 != 2'b11) begin
            tag = "R5"; return {3'b001, 2'd2, 6'h07};
        end
        if (l2x && ((hm && !e2[0]) || (!hm && t2))) begin
            tag = "R7"; return {3'b001, 2'd2, 6'h07};
        end
        if (l3x) begin tag = "R8"; return {3'b001, 2'd3, 6'h07}; end
        tag = "R9";
        return {3'b100, 8'h00};
    endfunction

    task automatic compare(input string tag, input logic [10:0] exp);
        logic [10:0] act = {allow_o, undef_o, trap_o, tgt_lvl_o, syn_o};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s vec=%05h actual=%03h expected=%03h", tag, vec, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        string tag;
        logic [10:0] e;
        // R1: reset state
        vec = 17'h1ffff;
        repeat (3) @(negedge clk);
        compare("R1", 11'h000);
        rst_n = 1'b1;
        // R11: priority directed case, level 0 with L1 trap pending but halt rule first
        vec = 17'h0;
        vec[2] = 1'b1; vec[5] = 1'b1; vec[6] = 1'b1; vec[14] = 1'b1;
        vec[15] = 1'b1; vec[16] = 1'b1;
        @(negedge clk);
        compare("R11", {3'b010, 8'h00});
        // R11: L1 trap beats L2 trap-FP at level 1
        vec = 17'h0; vec[1:0] = 2'd1; vec[3] = 1'b1; vec[4] = 1'b1; vec[13] = 1'b1;
        @(negedge clk);
        compare("R11", {3'b001, 2'd1, 6'h07});
        // R12: hold inputs and check the verdict persists
        @(negedge clk);
        compare("R12", {3'b001, 2'd1, 6'h07});
        // exhaustive sweep (R2..R10), one vector per cycle
        for (int i = 0; i < (1 << 17); i++) begin
            vec = i[16:0];
            e = model(vec, tag);
            @(negedge clk);
            compare(tag, e);
        end
        // R1 again: reset reasserted clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        compare("R1", 11'h000);
        finish_run();
    end
endmodule